// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Host Controller

This block is the host side of a three-wire serial EEPROM link. Requests arrive on a valid/ready handshake and carry an operation, a 6-bit word address and a 16-bit data word. The controller turns each request into a serial frame on the chip-select, shift-clock and data-in pins, and it samples the memory's data-out pin. It returns a one-cycle done pulse with the 16-bit read result and a timeout flag.

All pin timing is counted in system clock cycles. Parameters set the shift-clock high and low phases and the minimum chip-select low time. After an erase or write operation, the controller drops chip select for the minimum low time. It then raises chip select again and samples data-out on every clock until the memory reports ready. If ready does not appear within a parameterised number of samples, the controller gives up and flags a timeout.

Top module: `ser_eeprom_host`

## Requirements
- R1: Every frame starts with a 1, then a 2-bit opcode, then a 6-bit address, all sent most significant bit first. The opcode is 10 for read, 01 for write, 11 for erase and 00 for the special commands. The req_op encoding is 0 read, 1 write, 2 erase, 3 enable, 4 disable, 5 erase-all and 6 write-all.
- R2: The special commands send fixed address fields, with the unused low bits driven 0. These are 110000 for enable, 000000 for disable, 100000 for erase-all and 010000 for write-all. Enable, disable, erase and erase-all frames last exactly 9 shift clocks.
- R3: Write and write-all frames append req_wdata, most significant bit first, which makes 25 shift clocks.
- R4: A read frame lasts 26 shift clocks, and data-in is held 0 after the address. Of the 17 data-out samples after the address, the first is dropped and the next 16 form rsp_rdata, most significant bit first. rsp_rdata is valid while rsp_done is high. Commands other than read return 0.
- R5: The shift clock stays high for at least SK_HI_CYC cycles and low for at least SK_LO_CYC cycles before each rise. It is high only while chip select is high.
- R6: Data-in changes only while the shift clock is low. Data-out is sampled at the cycle in which the shift clock rises.
- R7: After the frame of a write, erase, erase-all or write-all, chip select stays low for at least CS_LO_CYC cycles before it is raised for status polling.
- R8: While polling, data-out is sampled on every clock with chip select high: 0 means busy and 1 means ready. A 1 ends the command with rsp_done high and rsp_timeout low, and chip select drops.
- R9: If POLL_LIMIT consecutive samples read busy, the command ends with rsp_done and rsp_timeout both high.
- R10: After reset, and after every done pulse, req_ready and chip select stay low for at least CS_LO_CYC cycles.
- R11: A request is taken in the cycle where req_valid and req_ready are both high. In the next cycle req_ready is low and chip select is high. req_ready is never high while chip select is high.
- R12: req_op value 7 is sent as a disable command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_op | input | 3 | Operation code (see R1) |
| req_addr | input | 6 | Word address |
| req_wdata | input | 16 | Data for write and write-all |
| rsp_done | output | 1 | One-cycle pulse when a command completes |
| rsp_timeout | output | 1 | With rsp_done: status polling gave up |
| rsp_rdata | output | 16 | Read result, valid with rsp_done |
| ee_cs | output | 1 | Chip select to the memory |
| ee_sk | output | 1 | Shift clock to the memory |
| ee_di | output | 1 | Serial data to the memory |
| ee_do | input | 1 | Serial data and ready/busy status from the memory |

## Verification
A frame is due one cycle after acceptance. Each bit occupies SK_LO_CYC plus SK_HI_CYC cycles, so a result arrives only after a data-dependent wait of 9, 25 or 26 bit times, plus the gap and polling time for programming commands. The bench therefore never predicts an absolute cycle for a result. Its memory model decodes each frame at the falling edge of chip select and compares it with the frame queued by the driver. The response monitor pops the expected read data and timeout flag at whichever falling clock edge shows rsp_done. Only the cycle counts that the block guarantees are measured directly, all as lower bounds: clock phase lengths, the chip-select low gaps, and the ready-low interval of at least CS_LO_CYC cycles after each done pulse.

// File: rtl/ser_eeprom_host.sv
module ser_eeprom_host #(
  parameter int SK_HI_CYC  = 32,
  parameter int SK_LO_CYC  = 32,
  parameter int CS_LO_CYC  = 32,
  parameter int POLL_LIMIT = 1400000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [2:0]  req_op,
  input  logic [5:0]  req_addr,
  input  logic [15:0] req_wdata,
  output logic        rsp_done,
  output logic        rsp_timeout,
  output logic [15:0] rsp_rdata,
  output logic        ee_cs,
  output logic        ee_sk,
  output logic        ee_di,
  input  logic        ee_do
);

  localparam int TMAX0 = (SK_HI_CYC > SK_LO_CYC) ? SK_HI_CYC : SK_LO_CYC;
  localparam int TMAX  = (TMAX0 > CS_LO_CYC) ? TMAX0 : CS_LO_CYC;
  localparam int TW    = $clog2(TMAX + 1);
  localparam int PW    = $clog2(POLL_LIMIT + 1);
  localparam logic [TW-1:0] HI_END   = TW'(SK_HI_CYC - 1);
  localparam logic [TW-1:0] LO_END   = TW'(SK_LO_CYC - 1);
  localparam logic [TW-1:0] CS_END   = TW'(CS_LO_CYC - 1);
  localparam logic [PW-1:0] POLL_END = PW'(POLL_LIMIT - 1);
  localparam logic [4:0]    RD_FIRST = 5'd10;

  typedef enum logic [2:0] {S_IDLE, S_SHIFT, S_GAP, S_POLL, S_TAIL} st_t;

  st_t            st;
  logic [TW-1:0]  tmr;
  logic [PW-1:0]  pcnt;
  logic [31:0]    tx;
  logic [4:0]     nbits, bcnt;
  logic           is_rd, is_prog;
  logic           cs_r, sk_r, done_r, to_r;
  logic [15:0]    rdata;

  logic [8:0]  f_hdr;
  logic [4:0]  f_len;
  logic        f_prog, f_rd, f_dat;

  always_comb begin
    f_hdr  = {3'b100, 6'b000000};
    f_len  = 5'd9;
    f_prog = 1'b0;
    f_rd   = 1'b0;
    f_dat  = 1'b0;
    case (req_op)
      3'd0: begin f_hdr = {3'b110, req_addr}; f_len = 5'd26; f_rd = 1'b1; end
      3'd1: begin f_hdr = {3'b101, req_addr}; f_len = 5'd25; f_prog = 1'b1; f_dat = 1'b1; end
      3'd2: begin f_hdr = {3'b111, req_addr}; f_prog = 1'b1; end
      3'd3: f_hdr = {3'b100, 6'b110000};
      3'd5: begin f_hdr = {3'b100, 6'b100000}; f_prog = 1'b1; end
      3'd6: begin f_hdr = {3'b100, 6'b010000}; f_len = 5'd25; f_prog = 1'b1; f_dat = 1'b1; end
      default: f_hdr = {3'b100, 6'b000000};
    endcase
  end

  assign req_ready   = (st == S_IDLE);
  assign ee_cs       = cs_r;
  assign ee_sk       = sk_r;
  assign ee_di       = cs_r & tx[31];
  assign rsp_done    = done_r;
  assign rsp_timeout = to_r;
  assign rsp_rdata   = rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_TAIL;
      tmr     <= '0;
      pcnt    <= '0;
      tx      <= '0;
      nbits   <= '0;
      bcnt    <= '0;
      is_rd   <= 1'b0;
      is_prog <= 1'b0;
      cs_r    <= 1'b0;
      sk_r    <= 1'b0;
      done_r  <= 1'b0;
      to_r    <= 1'b0;
      rdata   <= '0;
    end else begin
      done_r <= 1'b0;
      to_r   <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            st      <= S_SHIFT;
            cs_r    <= 1'b1;
            sk_r    <= 1'b0;
            tmr     <= '0;
            bcnt    <= '0;
            nbits   <= f_len;
            is_rd   <= f_rd;
            is_prog <= f_prog;
            rdata   <= '0;
            tx      <= {f_hdr, (f_dat ? req_wdata : 16'h0000), 7'b0};
          end
        end
        S_SHIFT: begin
          if (!sk_r) begin
            if (tmr == LO_END) begin
              sk_r <= 1'b1;
              tmr  <= '0;
              if (is_rd && bcnt >= RD_FIRST) rdata <= {rdata[14:0], ee_do};
            end else begin
              tmr <= tmr + 1'b1;
            end
          end else if (tmr == HI_END) begin
            sk_r <= 1'b0;
            tmr  <= '0;
            tx   <= tx << 1;
            bcnt <= bcnt + 1'b1;
            if (bcnt == nbits - 1'b1) begin
              cs_r <= 1'b0;
              if (is_prog) begin
                st <= S_GAP;
              end else begin
                st     <= S_TAIL;
                done_r <= 1'b1;
              end
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_GAP: begin
          if (tmr == CS_END) begin
            st   <= S_POLL;
            cs_r <= 1'b1;
            tmr  <= '0;
            pcnt <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_POLL: begin
          if (ee_do || pcnt == POLL_END) begin
            st     <= S_TAIL;
            cs_r   <= 1'b0;
            tmr    <= '0;
            done_r <= 1'b1;
            to_r   <= ~ee_do;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        S_TAIL: begin
          if (tmr == CS_END) begin
            st  <= S_IDLE;
            tmr <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ser_eeprom_host_chk.sv
module ser_eeprom_host_chk #(
  parameter int SK_HI_CYC = 32,
  parameter int SK_LO_CYC = 32,
  parameter int CS_LO_CYC = 32
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic ee_cs,
  input logic ee_sk,
  input logic ee_di,
  input logic rsp_done,
  input logic rsp_timeout
);

  logic [31:0] hi_run, lo_run, cs_lo_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_run    <= '0;
      lo_run    <= '0;
      cs_lo_run <= '0;
    end else begin
      hi_run    <= ee_sk ? ((hi_run == '1) ? hi_run : hi_run + 1) : '0;
      lo_run    <= !ee_sk ? ((lo_run == '1) ? lo_run : lo_run + 1) : '0;
      cs_lo_run <= !ee_cs ? ((cs_lo_run == '1) ? cs_lo_run : cs_lo_run + 1) : '0;
    end
  end

  assert_sk_high_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ee_sk) |-> hi_run >= 32'(SK_HI_CYC));

  assert_sk_low_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_sk) |-> lo_run >= 32'(SK_LO_CYC));

  assert_sk_needs_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ee_sk |-> ee_cs);

  assert_di_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk && $past(ee_sk)) |-> $stable(ee_di));

  assert_cs_low_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ee_cs) |-> cs_lo_run >= 32'(CS_LO_CYC));

  assert_timeout_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_timeout |-> rsp_done);

  assert_ready_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !ee_cs);

  assert_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (ee_cs && !req_ready));

endmodule

bind ser_eeprom_host ser_eeprom_host_chk #(
  .SK_HI_CYC(SK_HI_CYC),
  .SK_LO_CYC(SK_LO_CYC),
  .CS_LO_CYC(CS_LO_CYC)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .ee_cs(ee_cs),
  .ee_sk(ee_sk),
  .ee_di(ee_di),
  .rsp_done(rsp_done),
  .rsp_timeout(rsp_timeout)
);

// File: tb/ser_eeprom_host_tb.sv
module ser_eeprom_host_tb;
  localparam int SKH = 2;
  localparam int SKL = 3;
  localparam int CSL = 4;
  localparam int PL  = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = '0;
  logic [5:0]  req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_done, rsp_timeout;
  logic [15:0] rsp_rdata;
  logic        ee_cs, ee_sk, ee_di, ee_do;

  ser_eeprom_host #(.SK_HI_CYC(SKH), .SK_LO_CYC(SKL), .CS_LO_CYC(CSL), .POLL_LIMIT(PL)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_timeout(rsp_timeout), .rsp_rdata(rsp_rdata),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  typedef struct { logic [31:0] bits; int len; string req; } frm_t;
  typedef struct { logic [15:0] rd; bit to; string req; } rsp_t;
  frm_t fq[$];
  rsp_t rq[$];

  function automatic logic [15:0] init_val(input int a);
    return 16'h5A00 ^ (16'(a) * 16'h0101);
  endfunction

  // memory model
  logic [15:0] mem [64];
  logic        en_st = 1'b0;
  int          busy = 0;
  int          busy_len = 0;
  logic        sk_q = 1'b0, cs_q = 1'b0;
  int          nrx = 0;
  logic [31:0] rx = '0;
  logic        rd_ph = 1'b0;
  logic [15:0] rd_sh = '0;
  logic        mdo = 1'b0;
  int          viol_hi = 0, viol_lo = 0, viol_cs = 0;
  int          run_sk = 0, run_cs = 0;

  initial for (int i = 0; i < 64; i++) mem[i] = init_val(i);

  assign ee_do = ee_cs ? (rd_ph ? mdo : (busy == 0)) : 1'b0;

  always @(posedge clk) begin
    logic [8:0] h;
    frm_t f;
    if (busy > 0) busy <= busy - 1;
    sk_q <= ee_sk;
    cs_q <= ee_cs;
    if (ee_cs && !cs_q) begin
      nrx <= 0; rx <= '0; rd_ph <= 1'b0;
    end else if (ee_cs && ee_sk && !sk_q) begin
      rx  <= {rx[30:0], ee_di};
      nrx <= nrx + 1;
      if (rd_ph) begin
        mdo   <= rd_sh[15];
        rd_sh <= rd_sh << 1;
      end else if (nrx == 8 && rx[7] && rx[6:5] == 2'b10) begin
        rd_ph <= 1'b1;
        mdo   <= 1'b0;
        rd_sh <= mem[{rx[4:0], ee_di}];
      end
    end else if (!ee_cs && cs_q && nrx > 0) begin
      rd_ph <= 1'b0;
      if (fq.size() == 0) begin
        chk(1'b0, "R1", "unexpected frame", rx, 32'h0);
      end else begin
        f = fq.pop_front();
        chk(nrx == f.len, f.req, "frame clock count", nrx, f.len);
        chk(rx == f.bits, f.req, "frame bits", rx, f.bits);
      end
      h = 9'(rx >> (nrx - 9));
      if (h[8]) begin
        case (h[7:6])
          2'b01: if (en_st) begin mem[h[5:0]] <= rx[15:0]; busy <= busy_len; end
          2'b11: if (en_st) begin mem[h[5:0]] <= 16'hFFFF; busy <= busy_len; end
          2'b00: case (h[5:4])
            2'b11: en_st <= 1'b1;
            2'b00: en_st <= 1'b0;
            2'b10: if (en_st) begin
              for (int i = 0; i < 64; i++) mem[i] <= 16'hFFFF;
              busy <= busy_len;
            end
            default: if (en_st) begin
              for (int i = 0; i < 64; i++) mem[i] <= rx[15:0];
              busy <= busy_len;
            end
          endcase
          default: ;
        endcase
      end
    end
  end

  // pin timing monitor (R5, R7, R10)
  always @(posedge clk) begin
    if (rst_n) begin
      if (ee_sk == sk_q) run_sk <= run_sk + 1;
      else begin
        if (sk_q && run_sk < SKH) viol_hi <= viol_hi + 1;
        if (!sk_q && run_sk < SKL) viol_lo <= viol_lo + 1;
        run_sk <= 1;
      end
      if (ee_cs == cs_q) run_cs <= run_cs + 1;
      else begin
        if (!cs_q && run_cs < CSL) viol_cs <= viol_cs + 1;
        run_cs <= 1;
      end
    end
  end

  // response monitor
  always @(negedge clk) begin
    rsp_t r;
    if (rst_n && rsp_done) begin
      if (rq.size() == 0) chk(1'b0, "R8", "unexpected done", 32'h1, 32'h0);
      else begin
        r = rq.pop_front();
        chk(rsp_rdata == r.rd, "R4", {"read data for ", r.req}, rsp_rdata, r.rd);
        chk(rsp_timeout == r.to, r.req, "timeout flag", rsp_timeout, r.to);
      end
    end
  end

  task automatic issue(input logic [2:0] op, input logic [5:0] a, input logic [15:0] d,
                       input logic [15:0] exp_rd, input bit exp_to, input int blen,
                       input string req);
    frm_t f;
    rsp_t r;
    int k;
    logic [8:0] hd;
    case (op)
      3'd0: begin hd = {3'b110, a}; f.len = 26; end
      3'd1: begin hd = {3'b101, a}; f.len = 25; end
      3'd2: begin hd = {3'b111, a}; f.len = 9; end
      3'd3: begin hd = 9'b100110000; f.len = 9; end
      3'd5: begin hd = 9'b100100000; f.len = 9; end
      3'd6: begin hd = 9'b100010000; f.len = 25; end
      default: begin hd = 9'b100000000; f.len = 9; end
    endcase
    if (f.len == 26) f.bits = {6'b0, hd, 17'b0};
    else if (f.len == 25) f.bits = {7'b0, hd, d};
    else f.bits = {23'b0, hd};
    f.req = (f.len == 25) ? "R3" : ((op == 3'd0) ? "R4" : req);
    fq.push_back(f);
    r.rd = exp_rd; r.to = exp_to; r.req = req;
    rq.push_back(r);
    busy_len = blen;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready && ee_cs, "R11", "ready low and cs high after accept", {req_ready, ee_cs}, 2'b01);
    while (!rsp_done) @(negedge clk);
    k = 0;
    while (!req_ready) begin k++; @(negedge clk); end
    chk(k >= CSL, "R10", "ready-low cycles after done", k, CSL);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ee_cs && !ee_sk && !req_ready && !rsp_done, "R10", "reset state",
        {ee_cs, ee_sk, req_ready, rsp_done}, 4'b0000);
    repeat (CSL) @(negedge clk);
    chk(req_ready, "R10", "ready after reset low time", req_ready, 1'b1);

    issue(3'd1, 6'd5, 16'hA5C3, 16'h0, 1'b0, 10, "R8");
    issue(3'd0, 6'd5, 16'h0, init_val(5), 1'b0, 0, "R4");
    issue(3'd3, 6'd0, 16'h0, 16'h0, 1'b0, 0, "R2");
    issue(3'd1, 6'd5, 16'hA5C3, 16'h0, 1'b0, 20, "R8");
    issue(3'd0, 6'd5, 16'h0, 16'hA5C3, 1'b0, 0, "R4");
    issue(3'd0, 6'd6, 16'h0, init_val(6), 1'b0, 0, "R4");
    issue(3'd2, 6'd5, 16'h0, 16'h0, 1'b0, 15, "R1");
    issue(3'd0, 6'd5, 16'h0, 16'hFFFF, 1'b0, 0, "R6");
    issue(3'd6, 6'd0, 16'h1234, 16'h0, 1'b0, 30, "R7");
    issue(3'd0, 6'd0, 16'h0, 16'h1234, 1'b0, 0, "R4");
    issue(3'd0, 6'd63, 16'h0, 16'h1234, 1'b0, 0, "R4");
    issue(3'd5, 6'd0, 16'h0, 16'h0, 1'b0, 30, "R2");
    issue(3'd0, 6'd17, 16'h0, 16'hFFFF, 1'b0, 0, "R4");
    issue(3'd1, 6'd9, 16'hBEEF, 16'h0, 1'b1, 2 * PL, "R9");
    repeat (3 * PL) @(negedge clk);
    issue(3'd0, 6'd9, 16'h0, 16'hBEEF, 1'b0, 0, "R4");
    issue(3'd1, 6'd10, 16'h0F0F, 16'h0, 1'b0, 0, "R8");
    issue(3'd0, 6'd10, 16'h0, 16'h0F0F, 1'b0, 0, "R4");
    issue(3'd7, 6'd0, 16'h0, 16'h0, 1'b0, 0, "R12");
    issue(3'd1, 6'd11, 16'h7777, 16'h0, 1'b0, 0, "R12");
    issue(3'd0, 6'd11, 16'h0, 16'hFFFF, 1'b0, 0, "R12");

    repeat (10) @(negedge clk);
    chk(fq.size() == 0, "R1", "frames left unsent", fq.size(), 0);
    chk(rq.size() == 0, "R8", "responses left unseen", rq.size(), 0);
    chk(viol_hi == 0, "R5", "short sk high phases", viol_hi, 0);
    chk(viol_lo == 0, "R5", "short sk low phases", viol_lo, 0);
    chk(viol_cs == 0, "R7", "short cs low gaps", viol_cs, 0);
    finish_run();
  end

endmodule